// File: doc/BRIEF.md
# Despreading Symbol Detector

This block is the receive-side detector for one user of a two-user direct-sequence spread channel. Each data bit travels as seven chips: the bit XORed with that user's 7-chip pseudo-noise code. The detector rebuilds the same code locally from the transmitter's seed and XORs it off the incoming chips. It gathers the despread chips in a 7-stage serial-in parallel-out register and, once per symbol, decides whether the bit was 1 or 0 by majority vote.

The transmitter and the receiver run from one master clock, and that shared clock is the only timing reference. The block does no code acquisition and no tracking. After reset, a start-up synchronizer waits a fixed number of clocks and then arms the detector. From that edge on, one chip is taken on every clock and a decision comes out every seven clocks. The decision stream has no back-pressure, because chips arrive at a rate the master clock fixes and cannot be paused. A consumer must take each `sym_valid` pulse in the cycle it appears. For that reason the output is a valid-qualified stream with no ready input.

Top module: `despread_detector`

## Requirements
- R1: While `rst_n` is low, `det_armed`, `sym_valid` and `sym_bit` are all 0.
- R2: `det_armed` is 0 for the first two rising edges after `rst_n` goes high. It is 1 from the second edge onward and stays 1 until the next reset.
- R3: Chips presented before `det_armed` is high are not taken. Chip 0 of the first symbol is the value on `rx_chip` at the first rising edge where `det_armed` is already 1. No `sym_valid` pulse occurs while `det_armed` is 0.
- R4: The local code comes from a 3-stage LFSR. The state shifts toward its MSB, the new LSB is state[2] XOR state[0], and the chip output is state[2]. With the default seed 3'b001, the chips of every symbol are, in order, 0,0,1,1,1,0,1. The code advances one chip per armed clock and restarts in step with each symbol. Each despread chip is `rx_chip` XOR the local chip.
- R5: The decision is 1 when at least 4 of a symbol's 7 despread chips are 1, and 0 otherwise. Up to 3 corrupted chips therefore leave the bit intact, while 4 or more invert it.
- R6: `sym_valid` is a single-cycle pulse. The first pulse is high after the tenth rising edge following reset release, which is one edge after the symbol's seventh chip. `sym_bit` changes only together with a pulse and holds its value between pulses.
- R7: Symbols follow back to back with no idle chip. Consecutive `sym_valid` pulses are exactly 7 clocks apart, and each decision matches its symbol in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one chip per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_chip | input | 1 | Received spread chip |
| det_armed | output | 1 | Start-up synchronizer done; detection running |
| sym_valid | output | 1 | One-cycle pulse marking a new decision |
| sym_bit | output | 1 | Recovered data bit, held between pulses |

## Verification
Two things happen on the same clock edge. The majority decision of symbol n reads the full collection register, and on that same edge chip 0 of symbol n+1 shifts into that register while the code generator wraps to its first chip. The bench provokes this overlap with a continuous stream of symbols that have alternating and random bits, and with chip-error masks at exactly 3 and exactly 4 flips. It judges the result by checking that every decision matches the queued expectation and that the pulses arrive exactly 7 clocks apart. A fault that mixes one symbol's chips into another's shows up as a wrong bit on the boundary-weight symbols or as a wrong pulse spacing.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  // chips per symbol for a maximal-length register of the given width
  function automatic int unsigned code_len(input int unsigned width);
    return (1 << width) - 1;
  endfunction

  // smallest count of ones that wins a strict majority out of n
  function automatic int unsigned majority_min(input int unsigned n);
    return n / 2 + 1;
  endfunction

  // a registered symbol decision
  typedef struct packed {
    logic valid;
    logic value;
  } decision_t;

endpackage

// File: rtl/dsd_startup_sync.sv
module dsd_startup_sync #(
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed_o
);

  localparam int unsigned CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);

  logic [CNT_W-1:0] wait_cnt;
  logic             armed_q;

  // count edges after reset; raise the flag on the last counted edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      armed_q  <= 1'b0;
    end else if (!armed_q) begin
      wait_cnt <= wait_cnt + 1'b1;
      if (wait_cnt == CNT_W'(WAIT_CYCLES - 1)) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign armed_o = armed_q;

endmodule

// File: rtl/dsd_pn_gen.sv
module dsd_pn_gen #(
  parameter int unsigned     WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b101,
  parameter logic [WIDTH-1:0] SEED = 3'b001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic chip_o
);

  logic [WIDTH-1:0] lfsr_q;
  logic             fb;

  // feedback is the parity of the tapped stages
  assign fb = ^(lfsr_q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
    end else if (adv_i) begin
      lfsr_q <= {lfsr_q[WIDTH-2:0], fb};
    end
  end

  assign chip_o = lfsr_q[WIDTH-1];

endmodule

// File: rtl/dsd_sipo.sv
module dsd_sipo #(
  parameter int unsigned DEPTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [DEPTH-1:0] word_o
);

  logic [DEPTH-1:0] stage_q;

  // one flop per stage; stage 0 takes the new chip, others take their neighbour
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic stage_d;
    if (g == 0) begin : g_head
      assign stage_d = din_i;
    end else begin : g_body
      assign stage_d = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= 1'b0;
      end else if (shift_i) begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign word_o = stage_q;

endmodule

// File: rtl/dsd_majority.sv
module dsd_majority
  import dsd_pkg::*;
#(
  parameter int unsigned DEPTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             judge_i,
  input  logic [DEPTH-1:0] word_i,
  output logic             valid_o,
  output logic             bit_o
);

  localparam int unsigned CW     = $clog2(DEPTH + 1);
  localparam int unsigned THRESH = majority_min(DEPTH);

  logic [CW-1:0] ones;
  decision_t     dec_q;

  // population count of the collected despread chips
  always_comb begin
    ones = '0;
    for (int i = 0; i < DEPTH; i++) begin
      ones = ones + CW'(word_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '0;
    end else begin
      dec_q.valid <= judge_i;
      if (judge_i) begin
        dec_q.value <= (ones >= CW'(THRESH));
      end
    end
  end

  assign valid_o = dec_q.valid;
  assign bit_o   = dec_q.value;

endmodule

// File: rtl/despread_detector.sv
module despread_detector
  import dsd_pkg::*;
#(
  parameter int unsigned      PN_W        = 3,
  parameter logic [PN_W-1:0]  PN_TAPS     = 3'b101,
  parameter logic [PN_W-1:0]  PN_SEED     = 3'b001,
  parameter int unsigned      SYNC_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_chip,
  output logic det_armed,
  output logic sym_valid,
  output logic sym_bit
);

  localparam int unsigned LEN  = code_len(PN_W);
  localparam int unsigned PH_W = $clog2(LEN);

  logic            armed;
  logic            pn_chip;
  logic            despread;
  logic [LEN-1:0]  chip_word;
  logic [PH_W-1:0] phase_q;
  logic            sym_due_q;

  dsd_startup_sync #(
    .WAIT_CYCLES (SYNC_CYCLES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed_o (armed)
  );

  dsd_pn_gen #(
    .WIDTH (PN_W),
    .TAPS  (PN_TAPS),
    .SEED  (PN_SEED)
  ) u_pn (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (armed),
    .chip_o (pn_chip)
  );

  assign despread = rx_chip ^ pn_chip;

  dsd_sipo #(
    .DEPTH (LEN)
  ) u_sipo (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (armed),
    .din_i   (despread),
    .word_o  (chip_word)
  );

  // divide-by-LEN symbol timer: flags a full register one edge after the last chip
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      sym_due_q <= 1'b0;
    end else begin
      sym_due_q <= armed && (phase_q == PH_W'(LEN - 1));
      if (armed) begin
        phase_q <= (phase_q == PH_W'(LEN - 1)) ? '0 : phase_q + 1'b1;
      end
    end
  end

  dsd_majority #(
    .DEPTH (LEN)
  ) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .judge_i (sym_due_q),
    .word_i  (chip_word),
    .valid_o (sym_valid),
    .bit_o   (sym_bit)
  );

  assign det_armed = armed;

endmodule

// File: rtl/despread_detector_chk.sv
module despread_detector_chk
  import dsd_pkg::*;
#(
  parameter int unsigned PN_W        = 3,
  parameter int unsigned SYNC_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic det_armed,
  input logic sym_valid,
  input logic sym_bit
);

  localparam int unsigned LEN = code_len(PN_W);
  localparam int unsigned EW  = (SYNC_CYCLES < 2) ? 1 : $clog2(SYNC_CYCLES + 1);
  localparam int unsigned GW  = $clog2(LEN + 2);

  logic [EW-1:0] edge_cnt;
  logic [GW-1:0] gap_cnt;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      gap_cnt  <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (edge_cnt != EW'(SYNC_CYCLES)) edge_cnt <= edge_cnt + 1'b1;
      if (sym_valid) begin
        gap_cnt <= GW'(1);
        seen_q  <= 1'b1;
      end else if (det_armed) begin
        gap_cnt <= gap_cnt + 1'b1;
      end else begin
        gap_cnt <= '0;
      end
    end
  end

  // R2
  armed_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt == EW'(SYNC_CYCLES)) == det_armed);

  // R2
  armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_armed |=> det_armed);

  // R3
  quiet_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_armed |-> !sym_valid);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);

  // R6
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> $stable(sym_bit));

  // R7
  symbol_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (gap_cnt == (seen_q ? GW'(LEN) : GW'(LEN + 1))));

endmodule

bind despread_detector despread_detector_chk #(
  .PN_W        (PN_W),
  .SYNC_CYCLES (SYNC_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .det_armed (det_armed),
  .sym_valid (sym_valid),
  .sym_bit   (sym_bit)
);

// File: tb/despread_detector_tb.sv
module despread_detector_tb;

  localparam int CLK_PERIOD = 10;
  localparam bit PN_SEQ [7] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_chip = 1'b0;
  logic det_armed, sym_valid, sym_bit;

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  int last_valid_cyc = -1;
  bit prev_valid = 1'b0;
  bit mon_on = 1'b0;
  bit exp_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  despread_detector u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_chip   (rx_chip),
    .det_armed (det_armed),
    .sym_valid (sym_valid),
    .sym_bit   (sym_bit)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: queue the expected decision, then drive the 7 chips (R4, R5)
  task automatic send_sym(input bit b, input logic [6:0] err);
    exp_q.push_back(b ^ ($countones(err) >= 4));
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      rx_chip = b ^ PN_SEQ[i] ^ err[i];
    end
  endtask

  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  // monitor
  always @(negedge clk) begin
    if (rst_n && ncyc > 0) begin
      if (ncyc <= 3) check("R2", "det_armed", int'(det_armed), (ncyc >= 2) ? 1 : 0);
      if (!det_armed) check("R3", "sym_valid before arming", int'(sym_valid), 0);
      if (sym_valid && mon_on) begin
        check("R6", "pulse width", int'(prev_valid), 0);
        if (last_valid_cyc < 0) check("R6", "first decision cycle", ncyc, 10);
        else check("R7", "decision spacing", ncyc - last_valid_cyc, 7);
        last_valid_cyc = ncyc;
        if (exp_q.size() == 0) begin
          check("R7", "unexpected decision", 1, 0);
        end else begin
          check("R5", "decided bit", int'(sym_bit), int'(exp_q.pop_front()));
        end
      end
      prev_valid = sym_valid;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL R7 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "det_armed in reset", int'(det_armed), 0);
    check("R1", "sym_valid in reset", int'(sym_valid), 0);
    check("R1", "sym_bit in reset", int'(sym_bit), 0);
    mon_on = 1'b1;
    rst_n = 1'b1;
    rx_chip = 1'b1;          // R3: junk chip for edge 1
    @(negedge clk);
    rx_chip = 1'b0;          // R3: junk chip for edge 2
    // clean symbols, each bit value
    send_sym(1'b1, 7'b0000000);
    send_sym(1'b0, 7'b0000000);
    send_sym(1'b1, 7'b0000000);
    // R5 boundary: three errors keep the bit, four invert it
    send_sym(1'b1, 7'b0010101);
    send_sym(1'b0, 7'b1100010);
    send_sym(1'b1, 7'b1010101);
    send_sym(1'b0, 7'b0001111);
    send_sym(1'b1, 7'b1111111);
    send_sym(1'b0, 7'b1000000);
    // R7 continuous random stream
    for (int k = 0; k < 24; k++) begin
      send_sym(1'($urandom % 2), 7'($urandom % 128));
    end
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    check("R7", "pending decisions", exp_q.size(), 0);
    finish_run();
  end

endmodule